// File: doc/BRIEF.md
# Instruction Operand Decode Unit

This block sits between instruction fetch and execution. It takes a 32-bit instruction word and splits it into its fields. From those fields it builds the operand that the executing instruction will consume. The operand starts as a signed 16-bit immediate. An index register may be added to it. The sum may then be used as the address of a memory word, and that word becomes the operand value. The block reads the register file through a combinational read port. When indirection is requested, it makes a single one-cycle memory read.

The caller marks whether the operand is used as a destination. A destination must name something writable. It may be a bare index register, with no indirection and a zero immediate. It may also be an indirect memory word. Any other form is reported as an addressing fault. Register 0 can never act as an index: an index field of zero means that no index register is added. The stack pointer (13), frame pointer (14) and program counter (15) are read like any other register. Each accepted instruction produces exactly one output strobe carrying the decoded fields, the operand value and the destination description.

Top module: `operand_decode`

## Requirements
- R1: On the output strobe, the opcode equals instruction bits 31:25 and the main register equals bits 23:20.
- R2: Bits 15:0 are sign-extended to 32 bits, so 0x8000 yields 0xFFFF8000 and 0x7FFF yields 0x00007FFF.
- R3: When the index field (bits 19:16) is 0, no register contents are added, whatever register 0 holds.
- R4: When the index field is non-zero, the effective total is the sign-extended immediate plus the contents of that register, modulo 2^32.
- R5: With the indirect flag (bit 24) clear, the operand value is the total itself. The strobe follows one cycle after acceptance, and no memory read is issued. Such instructions may be accepted on consecutive cycles.
- R6: With the indirect flag set, the memory read request is raised in the acceptance cycle with the address equal to the total. The read data returned in the next cycle becomes the operand value. The strobe comes two cycles after acceptance.
- R7: For a destination operand with the indirect flag clear, a non-zero index field and a zero immediate, the register-destination enable is set. The destination register is the index field and the value is that register's contents.
- R8: For a destination operand with the indirect flag set, the memory-destination enable is set and the destination address equals the total. At most one of the register enable, the memory enable and the fault flag is ever set.
- R9: For a destination operand with the indirect flag clear and either a zero index field or a non-zero immediate, the fault flag is set and both destination enables are clear. No memory read is issued, and the strobe follows one cycle after acceptance.
- R10: The ready output is low in the cycle after an indirect instruction is accepted. An instruction offered then is not accepted and produces no read and no strobe.
- R11: After reset, the strobe and the read request are low and ready is high.
- R12: For a non-destination operand, both destination enables and the fault flag are clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| in_valid | input | 1 | Instruction word offered |
| in_ready | output | 1 | Block can accept an instruction this cycle |
| in_word | input | 32 | Instruction word |
| in_is_dst | input | 1 | Operand is used as a destination |
| rf_idx | output | 4 | Register file read address (index field) |
| rf_rdata | input | 32 | Register file read data, combinational |
| mem_rd | output | 1 | Memory read request for indirection |
| mem_addr | output | 32 | Memory read address |
| mem_rdata | input | 32 | Memory read data, valid the cycle after the request |
| op_valid | output | 1 | Output strobe |
| op_code | output | 7 | Decoded opcode |
| op_mreg | output | 4 | Decoded main register number |
| op_value | output | 32 | Operand value |
| dst_reg_en | output | 1 | Destination is a register |
| dst_reg | output | 4 | Destination register number |
| dst_mem_en | output | 1 | Destination is a memory word |
| dst_addr | output | 32 | Destination memory address |
| addr_fault | output | 1 | Destination operand addresses nothing |

## Verification
The read request and its address are combinational. The bench checks them one nanosecond after it drives the instruction, before the accepting edge. A direct operand and a faulting destination are due at the falling edge that follows the accepting edge. An indirect operand is due one falling edge later. At the intermediate falling edge the bench confirms that there is no strobe yet and that ready is low. The bench drives every input on falling edges and samples every output there, so each result is read at exactly the cycle that its register count predicts.

// File: rtl/opdec_pkg.sv
package opdec_pkg;

  localparam int unsigned DEF_DATA_W = 32;
  localparam int unsigned DEF_OPC_W  = 7;
  localparam int unsigned DEF_REG_AW = 4;
  localparam int unsigned DEF_IMM_W  = 16;

  typedef enum logic [1:0] {
    DK_NONE  = 2'd0,
    DK_REG   = 2'd1,
    DK_MEM   = 2'd2,
    DK_FAULT = 2'd3
  } dst_kind_e;

  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_WAIT = 1'b1
  } dec_state_e;

endpackage

// File: rtl/opdec_split.sv
module opdec_split #(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned OPC_W  = 7,
  parameter int unsigned REG_AW = 4,
  parameter int unsigned IMM_W  = 16,
  localparam int unsigned XREG_LSB = IMM_W,
  localparam int unsigned MREG_LSB = IMM_W + REG_AW,
  localparam int unsigned IND_BIT  = IMM_W + 2 * REG_AW,
  localparam int unsigned OPC_LSB  = IND_BIT + 1,
  localparam int unsigned INSTR_W  = OPC_LSB + OPC_W
) (
  input  logic [INSTR_W-1:0] word,
  output logic [OPC_W-1:0]   opcode,
  output logic               ind,
  output logic [REG_AW-1:0]  mreg,
  output logic [REG_AW-1:0]  xreg,
  output logic [DATA_W-1:0]  imm_ext,
  output logic               imm_zero
);

  logic [IMM_W-1:0] imm_raw;

  assign opcode   = word[OPC_LSB +: OPC_W];
  assign ind      = word[IND_BIT];
  assign mreg     = word[MREG_LSB +: REG_AW];
  assign xreg     = word[XREG_LSB +: REG_AW];
  assign imm_raw  = word[IMM_W-1:0];
  assign imm_zero = (imm_raw == '0);

  generate
    if (DATA_W > IMM_W) begin : g_sext
      assign imm_ext = {{(DATA_W-IMM_W){imm_raw[IMM_W-1]}}, imm_raw};
    end else begin : g_trunc
      assign imm_ext = imm_raw[DATA_W-1:0];
    end
  endgenerate

endmodule

// File: rtl/opdec_ea.sv
module opdec_ea #(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned REG_AW = 4
) (
  input  logic [REG_AW-1:0] xreg,
  input  logic [DATA_W-1:0] imm_ext,
  output logic [REG_AW-1:0] rf_idx,
  input  logic [DATA_W-1:0] rf_rdata,
  output logic [DATA_W-1:0] total
);

  logic              has_idx;
  logic [DATA_W-1:0] idx_part;

  assign rf_idx   = xreg;
  assign has_idx  = (xreg != '0);
  assign idx_part = has_idx ? rf_rdata : '0;
  assign total    = imm_ext + idx_part;

endmodule

// File: rtl/opdec_dest.sv
module opdec_dest
  import opdec_pkg::*;
#(
  parameter int unsigned REG_AW = 4
) (
  input  logic              is_dst,
  input  logic              ind,
  input  logic [REG_AW-1:0] xreg,
  input  logic              imm_zero,
  output dst_kind_e         kind
);

  always_comb begin
    if (!is_dst) begin
      kind = DK_NONE;
    end else if (ind) begin
      kind = DK_MEM;
    end else if ((xreg != '0) && imm_zero) begin
      kind = DK_REG;
    end else begin
      kind = DK_FAULT;
    end
  end

endmodule

// File: rtl/opdec_ctrl.sv
module opdec_ctrl
  import opdec_pkg::*;
#(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned OPC_W  = 7,
  parameter int unsigned REG_AW = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic              need_rd,
  input  logic [OPC_W-1:0]  opcode,
  input  logic [REG_AW-1:0] mreg,
  input  logic [REG_AW-1:0] xreg,
  input  dst_kind_e         kind,
  input  logic [DATA_W-1:0] total,
  output logic              mem_rd,
  output logic [DATA_W-1:0] mem_addr,
  input  logic [DATA_W-1:0] mem_rdata,
  output logic              op_valid,
  output logic [OPC_W-1:0]  op_code,
  output logic [REG_AW-1:0] op_mreg,
  output logic [DATA_W-1:0] op_value,
  output logic              dst_reg_en,
  output logic [REG_AW-1:0] dst_reg,
  output logic              dst_mem_en,
  output logic [DATA_W-1:0] dst_addr,
  output logic              addr_fault
);

  // reset: asserted asynchronously, released through two flops
  logic [1:0] rst_pipe_q;
  logic       rst_sn;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe_q <= 2'b00;
    else        rst_pipe_q <= {rst_pipe_q[0], 1'b1};
  end
  assign rst_sn = rst_pipe_q[1];

  dec_state_e state_q, state_d;
  logic       accept, load_dir, load_ind, out_en;

  // held fields while the indirect read is outstanding
  logic [OPC_W-1:0]  p_opcode_q;
  logic [REG_AW-1:0] p_mreg_q, p_xreg_q;
  dst_kind_e         p_kind_q;
  logic [DATA_W-1:0] p_total_q;

  // next values of the output registers
  logic [OPC_W-1:0]  code_d;
  logic [REG_AW-1:0] mreg_d, dreg_d;
  logic [DATA_W-1:0] value_d, daddr_d;
  dst_kind_e         kind_d;

  assign in_ready = rst_sn && (state_q == ST_IDLE);
  assign accept   = in_valid && in_ready;
  assign mem_rd   = accept && need_rd;
  assign mem_addr = total;
  assign load_dir = accept && !need_rd;
  assign load_ind = (state_q == ST_WAIT);
  assign out_en   = load_dir || load_ind;

  always_comb begin
    state_d = state_q;
    case (state_q)
      ST_IDLE: if (mem_rd) state_d = ST_WAIT;
      ST_WAIT: state_d = ST_IDLE;
      default: state_d = ST_IDLE;
    endcase
  end

  always_comb begin
    if (load_ind) begin
      code_d  = p_opcode_q;
      mreg_d  = p_mreg_q;
      dreg_d  = p_xreg_q;
      kind_d  = p_kind_q;
      value_d = mem_rdata;
      daddr_d = p_total_q;
    end else begin
      code_d  = opcode;
      mreg_d  = mreg;
      dreg_d  = xreg;
      kind_d  = kind;
      value_d = total;
      daddr_d = total;
    end
  end

  always_ff @(posedge clk or negedge rst_sn) begin
    if (!rst_sn) begin
      state_q  <= ST_IDLE;
      op_valid <= 1'b0;
    end else begin
      state_q  <= state_d;
      op_valid <= out_en;
    end
  end

  always_ff @(posedge clk or negedge rst_sn) begin
    if (!rst_sn) begin
      p_opcode_q <= '0;
      p_mreg_q   <= '0;
      p_xreg_q   <= '0;
      p_kind_q   <= DK_NONE;
      p_total_q  <= '0;
    end else if (mem_rd) begin
      p_opcode_q <= opcode;
      p_mreg_q   <= mreg;
      p_xreg_q   <= xreg;
      p_kind_q   <= kind;
      p_total_q  <= total;
    end
  end

  always_ff @(posedge clk or negedge rst_sn) begin
    if (!rst_sn) begin
      op_code    <= '0;
      op_mreg    <= '0;
      op_value   <= '0;
      dst_reg    <= '0;
      dst_addr   <= '0;
      dst_reg_en <= 1'b0;
      dst_mem_en <= 1'b0;
      addr_fault <= 1'b0;
    end else if (out_en) begin
      op_code    <= code_d;
      op_mreg    <= mreg_d;
      op_value   <= value_d;
      dst_reg    <= dreg_d;
      dst_addr   <= daddr_d;
      dst_reg_en <= (kind_d == DK_REG);
      dst_mem_en <= (kind_d == DK_MEM);
      addr_fault <= (kind_d == DK_FAULT);
    end
  end

  AST_RD_THEN_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
    mem_rd |=> ##1 op_valid);                                      // R6
  AST_RD_BLOCKS_NEXT: assert property (@(posedge clk) disable iff (!rst_n)
    mem_rd |=> !in_ready);                                         // R10
  AST_FAULT_NO_READ: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && kind == DK_FAULT) |-> !mem_rd);                     // R9
  AST_DST_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({dst_reg_en, dst_mem_en, addr_fault}));               // R8
  AST_DST_REG_NONZERO: assert property (@(posedge clk) disable iff (!rst_n)
    dst_reg_en |-> (dst_reg != '0));                               // R7

endmodule

// File: rtl/operand_decode.sv
module operand_decode
  import opdec_pkg::*;
#(
  parameter int unsigned DATA_W = DEF_DATA_W,
  parameter int unsigned OPC_W  = DEF_OPC_W,
  parameter int unsigned REG_AW = DEF_REG_AW,
  parameter int unsigned IMM_W  = DEF_IMM_W,
  localparam int unsigned INSTR_W = OPC_W + 1 + 2 * REG_AW + IMM_W
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               in_valid,
  output logic               in_ready,
  input  logic [INSTR_W-1:0] in_word,
  input  logic               in_is_dst,
  output logic [REG_AW-1:0]  rf_idx,
  input  logic [DATA_W-1:0]  rf_rdata,
  output logic               mem_rd,
  output logic [DATA_W-1:0]  mem_addr,
  input  logic [DATA_W-1:0]  mem_rdata,
  output logic               op_valid,
  output logic [OPC_W-1:0]   op_code,
  output logic [REG_AW-1:0]  op_mreg,
  output logic [DATA_W-1:0]  op_value,
  output logic               dst_reg_en,
  output logic [REG_AW-1:0]  dst_reg,
  output logic               dst_mem_en,
  output logic [DATA_W-1:0]  dst_addr,
  output logic               addr_fault
);

  logic [OPC_W-1:0]  f_opcode;
  logic              f_ind, f_imm_zero;
  logic [REG_AW-1:0] f_mreg, f_xreg;
  logic [DATA_W-1:0] f_imm, ea_total;
  dst_kind_e         d_kind;

  opdec_split #(
    .DATA_W(DATA_W), .OPC_W(OPC_W), .REG_AW(REG_AW), .IMM_W(IMM_W)
  ) u_split (
    .word     (in_word),
    .opcode   (f_opcode),
    .ind      (f_ind),
    .mreg     (f_mreg),
    .xreg     (f_xreg),
    .imm_ext  (f_imm),
    .imm_zero (f_imm_zero)
  );

  opdec_ea #(.DATA_W(DATA_W), .REG_AW(REG_AW)) u_ea (
    .xreg     (f_xreg),
    .imm_ext  (f_imm),
    .rf_idx   (rf_idx),
    .rf_rdata (rf_rdata),
    .total    (ea_total)
  );

  opdec_dest #(.REG_AW(REG_AW)) u_dest (
    .is_dst   (in_is_dst),
    .ind      (f_ind),
    .xreg     (f_xreg),
    .imm_zero (f_imm_zero),
    .kind     (d_kind)
  );

  opdec_ctrl #(.DATA_W(DATA_W), .OPC_W(OPC_W), .REG_AW(REG_AW)) u_ctrl (
    .clk        (clk),
    .rst_n      (rst_n),
    .in_valid   (in_valid),
    .in_ready   (in_ready),
    .need_rd    (f_ind),
    .opcode     (f_opcode),
    .mreg       (f_mreg),
    .xreg       (f_xreg),
    .kind       (d_kind),
    .total      (ea_total),
    .mem_rd     (mem_rd),
    .mem_addr   (mem_addr),
    .mem_rdata  (mem_rdata),
    .op_valid   (op_valid),
    .op_code    (op_code),
    .op_mreg    (op_mreg),
    .op_value   (op_value),
    .dst_reg_en (dst_reg_en),
    .dst_reg    (dst_reg),
    .dst_mem_en (dst_mem_en),
    .dst_addr   (dst_addr),
    .addr_fault (addr_fault)
  );

endmodule

// File: tb/operand_decode_bench.sv
`timescale 1ns/1ps
module operand_decode_bench;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        in_valid, in_ready, in_is_dst;
  logic [31:0] in_word;
  logic [3:0]  rf_idx;
  logic [31:0] rf_rdata;
  logic        mem_rd;
  logic [31:0] mem_addr, mem_rdata;
  logic        op_valid, dst_reg_en, dst_mem_en, addr_fault;
  logic [6:0]  op_code;
  logic [3:0]  op_mreg, dst_reg;
  logic [31:0] op_value, dst_addr;

  int n_chk = 0;
  int n_err = 0;
  bit done  = 1'b0;

  localparam int K_NONE = 0, K_REG = 1, K_MEM = 2, K_FAULT = 3;

  always #2 clk = ~clk;

  operand_decode u_operand_decode (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_word(in_word), .in_is_dst(in_is_dst), .rf_idx(rf_idx),
    .rf_rdata(rf_rdata), .mem_rd(mem_rd), .mem_addr(mem_addr),
    .mem_rdata(mem_rdata), .op_valid(op_valid), .op_code(op_code),
    .op_mreg(op_mreg), .op_value(op_value), .dst_reg_en(dst_reg_en),
    .dst_reg(dst_reg), .dst_mem_en(dst_mem_en), .dst_addr(dst_addr),
    .addr_fault(addr_fault)
  );

  function automatic logic [31:0] reg_val(input logic [3:0] a);
    return 32'h0001_0000 * a + 32'h0000_0100 + {28'd0, a};
  endfunction

  function automatic logic [31:0] mem_val(input logic [31:0] a);
    return a ^ 32'h5A5A_0000;
  endfunction

  assign rf_rdata = reg_val(rf_idx);

  always @(posedge clk) begin
    if (mem_rd) mem_rdata <= mem_val(mem_addr);
  end

  task automatic chk(input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  function automatic logic [31:0] total_of(input logic [31:0] w);
    logic [31:0] imm;
    imm = {{16{w[15]}}, w[15:0]};
    return imm + ((w[19:16] != 4'd0) ? reg_val(w[19:16]) : 32'd0);
  endfunction

  task automatic chk_out(input string req, input logic [31:0] w, input int kind);
    logic [31:0] tot, val;
    tot = total_of(w);
    val = w[24] ? mem_val(tot) : tot;
    chk(req, "op_valid", {31'd0, op_valid}, 32'd1);
    chk("R1", "op_code", {25'd0, op_code}, {25'd0, w[31:25]});
    chk("R1", "op_mreg", {28'd0, op_mreg}, {28'd0, w[23:20]});
    if (kind != K_FAULT) chk(req, "op_value", op_value, val);
    chk(req, "dst_reg_en", {31'd0, dst_reg_en}, {31'd0, kind == K_REG});
    chk(req, "dst_mem_en", {31'd0, dst_mem_en}, {31'd0, kind == K_MEM});
    chk(req, "addr_fault", {31'd0, addr_fault}, {31'd0, kind == K_FAULT});
    if (kind == K_REG) chk(req, "dst_reg", {28'd0, dst_reg}, {28'd0, w[19:16]});
    if (kind == K_MEM) chk(req, "dst_addr", dst_addr, tot);
  endtask

  // one instruction, alone, with its latency checked
  task automatic run_op(input string req, input logic [31:0] w,
                        input logic dst, input int kind);
    @(negedge clk);
    in_word = w; in_is_dst = dst; in_valid = 1'b1;
    #1;
    chk(w[24] ? "R6" : "R5", "mem_rd", {31'd0, mem_rd}, {31'd0, w[24]});
    if (w[24]) chk("R6", "mem_addr", mem_addr, total_of(w));
    @(negedge clk);
    in_valid = 1'b0;
    if (w[24]) begin
      chk("R6", "early op_valid", {31'd0, op_valid}, 32'd0);
      chk("R10", "in_ready", {31'd0, in_ready}, 32'd0);
      @(negedge clk);
    end
    chk_out(req, w, kind);
  endtask

  task automatic t_reset;
    chk("R11", "op_valid", {31'd0, op_valid}, 32'd0);
    chk("R11", "mem_rd", {31'd0, mem_rd}, 32'd0);
    chk("R11", "in_ready", {31'd0, in_ready}, 32'd1);
  endtask

  task automatic t_fields;
    run_op("R1", 32'h0860_0000, 1'b0, K_NONE);   // opcode 4, main reg 6
    run_op("R12", 32'h0C73_0000, 1'b0, K_NONE);  // opcode 6, R7 + R3
  endtask

  task automatic t_sign;
    run_op("R2", 32'h0220_8000, 1'b0, K_NONE);   // -32768
    run_op("R2", 32'h0220_7FFF, 1'b0, K_NONE);   // +32767
  endtask

  task automatic t_index;
    run_op("R3", 32'h0220_0024, 1'b0, K_NONE);   // R0 not added
    run_op("R4", 32'h0273_000C, 1'b0, K_NONE);   // R3 + 12
    run_op("R4", 32'h02AF_FFFF, 1'b0, K_NONE);   // R15 - 1
  endtask

  task automatic t_indirect;
    run_op("R6", 32'h0D43_0000, 1'b0, K_NONE);   // [R3]
    run_op("R6", 32'h0720_04D2, 1'b0, K_NONE);   // [1234], no index
  endtask

  task automatic t_dest;
    run_op("R7", 32'h0803_0000, 1'b1, K_REG);    // bare R3
    run_op("R7", 32'h080D_0000, 1'b1, K_REG);    // bare stack pointer
    run_op("R8", 32'h0725_FE89, 1'b1, K_MEM);    // [R5 - 375]
    run_op("R9", 32'h0820_1234, 1'b1, K_FAULT);  // plain immediate
    run_op("R9", 32'h0823_0001, 1'b1, K_FAULT);  // register plus offset
    run_op("R9", 32'h0860_0000, 1'b1, K_FAULT);  // nothing at all
  endtask

  task automatic t_back_to_back;
    @(negedge clk);
    in_word = 32'h0274_0010; in_is_dst = 1'b0; in_valid = 1'b1;
    @(negedge clk);
    in_word = 32'h0225_FFF0;
    chk_out("R5", 32'h0274_0010, K_NONE);
    @(negedge clk);
    in_valid = 1'b0;
    chk_out("R5", 32'h0225_FFF0, K_NONE);
    @(negedge clk);
    chk("R5", "idle op_valid", {31'd0, op_valid}, 32'd0);
  endtask

  task automatic t_busy;
    @(negedge clk);
    in_word = 32'h0D42_0003; in_is_dst = 1'b0; in_valid = 1'b1;
    @(negedge clk);
    in_word = 32'h0D49_0000;                     // offered while busy
    #1;
    chk("R10", "mem_rd while busy", {31'd0, mem_rd}, 32'd0);
    @(negedge clk);
    in_valid = 1'b0;
    chk_out("R6", 32'h0D42_0003, K_NONE);
    @(negedge clk);
    chk("R10", "no strobe for refused", {31'd0, op_valid}, 32'd0);
    @(negedge clk);
    chk("R10", "no late strobe", {31'd0, op_valid}, 32'd0);
  endtask

  initial begin
    #(4 * 200000);
    if (!done) begin
      n_chk++; n_err++;
      $display("FAIL watchdog: actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; in_valid = 1'b0; in_word = '0; in_is_dst = 1'b0;
    mem_rdata = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    t_reset();
    t_fields();
    t_sign();
    t_index();
    t_indirect();
    t_dest();
    t_back_to_back();
    t_busy();
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

endmodule